// File: doc/BRIEF.md
# Countdown Seconds Alarm with Wakeup

This block is a relative, seconds-resolution alarm. Software writes the number of seconds until expiry into a load register; the value is copied at once into a live countdown counter. While the run bit is set, the counter drops by one on each one-second tick pulse. On the tick that brings it from one to zero the alarm's pending flag is raised, and the counter then rests at zero until it is loaded again.

The pending flag is cleared by writing a one to it. It can drive the interrupt line when its interrupt enable is set, and, separately, the wakeup output when the wakeup configuration bit is set. A second, simpler alarm source also exists: an external match pulse raises its own pending flag when that source is enabled. Software can disable it, mask it and clear it. Both pending flags share the interrupt line. The recommended reprogramming order is: stop the countdown, write zero to the load register, wait, write the new count, then run again.

Top module: `sec_alarm_top`

## Requirements
- R1: After reset every register reads zero, the countdown is zero, and irq_o and wake_o are low.
- R2: A write to byte offset 0x20 stores the load value and copies it into the countdown. Reads at 0x20 return the load value and reads at 0x24 return the live countdown, both zero-extended.
- R3: The countdown decrements by one on a tick only while bit 0 at 0x28 is set and the count is non-zero. Without a tick, or with that bit clear, it holds.
- R4: The tick that takes the countdown from 1 to 0 sets the pending flag (bit 0 at 0x30) once. Afterwards the counter holds at zero and raises no further flags. Loading zero never sets the flag.
- R5: Writing 1 to bit 0 at 0x30 clears the pending flag. Writing 0 leaves it unchanged.
- R6: If the flag is set and cleared in the same cycle, it ends up set.
- R7: irq_o goes high one cycle after any pending flag is set while its interrupt enable is also set (bit 0 at 0x2C for the countdown, bit 0 at 0x48 for the second source). irq_o is low when no enabled flag is pending.
- R8: wake_o goes high one cycle after the countdown's pending flag is set while bit 0 at 0x50 is set. wake_o is low otherwise, whatever the interrupt enables are.
- R9: The second source's flag (bit 0 at 0x4C, cleared by writing 1) is set by match_i only while bit 0 at 0x44 is set. A match while that bit is clear is ignored.
- R10: Read data appears on rdata_o in the cycle after rd_en_i. Unmapped offsets read as zero.
- R11: A load write in the same cycle as a tick takes priority: the countdown takes the written value, not the decremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| match_i | input | 1 | Event pulse for the second alarm source |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Registered wakeup request |

## Verification
The assertions assume that tick_i is a single-cycle pulse and that a load value fits the countdown width. They also assume that the bus issues at most one access per cycle. The bench drives ticks as isolated pulses, uses load values far below the counter range of its small configuration, and never overlaps a read with a write. For load values 1 through 20 it sweeps a full countdown and predicts the expiry tick arithmetically from the load value.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_LOAD    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CUR     = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_RUN     = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IEN     = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_M_RUN   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_M_IEN   = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_M_PEND  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_WAKECFG = 8'h50;

  localparam int NSRC = 2;

  typedef struct packed {
    logic            wake_cfg;
    logic [NSRC-1:0] ien;
    logic [NSRC-1:0] run;
  } ctl_t;
endpackage

// File: rtl/alarm_countdown.sv
module alarm_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = tick_i && run_i && (cnt_q != '0) && !load_i;
  assign expire_o = step && (cnt_q == ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step)   cnt_q <= cnt_q - ONE;
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(tick_i && run_i)) |=> $stable(cnt_o));
  assert_rest_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == '0 && !load_i) |=> (cnt_o == '0));
  assert_expire_zero_R4: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_o == '0));
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (load_i && tick_i) |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/sa_regs.sv
module sa_regs
  import sa_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NSRC-1:0]    pend_i,
  output ctl_t               ctl_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [NSRC-1:0]    clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  ctl_t              ctl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign load_o     = wr_en_i && (addr_i == OFF_LOAD);
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign clr_o[0]   = wr_en_i && (addr_i == OFF_PEND)   && wdata_i[0];
  assign clr_o[1]   = wr_en_i && (addr_i == OFF_M_PEND) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      load_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_LOAD:    load_q         <= wdata_i[CNT_W-1:0];
        OFF_RUN:     ctl_q.run[0]   <= wdata_i[0];
        OFF_IEN:     ctl_q.ien[0]   <= wdata_i[0];
        OFF_M_RUN:   ctl_q.run[1]   <= wdata_i[0];
        OFF_M_IEN:   ctl_q.ien[1]   <= wdata_i[0];
        OFF_WAKECFG: ctl_q.wake_cfg <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_LOAD:    rd_mux = DATA_W'(load_q);
      OFF_CUR:     rd_mux = DATA_W'(cnt_i);
      OFF_RUN:     rd_mux[0] = ctl_q.run[0];
      OFF_IEN:     rd_mux[0] = ctl_q.ien[0];
      OFF_PEND:    rd_mux[0] = pend_i[0];
      OFF_M_RUN:   rd_mux[0] = ctl_q.run[1];
      OFF_M_IEN:   rd_mux[0] = ctl_q.ien[1];
      OFF_M_PEND:  rd_mux[0] = pend_i[1];
      OFF_WAKECFG: rd_mux[0] = ctl_q.wake_cfg;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign ctl_o   = ctl_q;
  assign rdata_o = rdata_q;

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/sec_alarm_top.sv
module sec_alarm_top
  import sa_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              match_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctl_t             ctl;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic [NSRC-1:0]  clr;
  logic [NSRC-1:0]  setv;
  logic [NSRC-1:0]  pend;
  logic             irq_q;
  logic             wake_q;

  sa_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt), .pend_i(pend),
    .ctl_o(ctl), .load_o(load), .load_val_o(load_val), .clr_o(clr),
    .rdata_o(rdata_o)
  );

  alarm_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val),
    .run_i(ctl.run[0]), .tick_i(tick_i), .cnt_o(cnt), .expire_o(expire)
  );

  assign setv[0] = expire;
  assign setv[1] = match_i && ctl.run[1];

  for (genvar s = 0; s < NSRC; s++) begin : g_flag
    alarm_flag u_flag (
      .clk(clk), .rst(rst), .set_i(setv[s]), .clr_i(clr[s]), .flag_o(pend[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |(pend & ctl.ien);
      wake_q <= pend[0] && ctl.wake_cfg;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && ctl.ien[0]) |=> irq_o);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !irq_o);
  assert_wake_rise_R8: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && ctl.wake_cfg) |=> wake_o);
  assert_wake_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !pend[0] |=> !wake_o);
  assert_match_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (match_i && !ctl.run[1] && !pend[1]) |=> !pend[1]);
endmodule

// File: tb/sim_sec_alarm_top.sv
`timescale 1ns/1ps
module sim_sec_alarm_top;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, match = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  sec_alarm_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .match_i(match),
    .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 wake", {31'b0, wake}, 0);
    rreg(8'h24, v); check("R1 cur", v, 0);
    rreg(8'h30, v); check("R1 pend", v, 0);
    rreg(8'h28, v); check("R1 run", v, 0);

    // R3 disabled: no decrement
    wreg(8'h20, 5);
    rreg(8'h20, v); check("R2 load readback", v, 5);
    rreg(8'h24, v); check("R2 cur copy", v, 5);
    repeat (3) pulse_tick();
    rreg(8'h24, v); check("R3 disabled hold", v, 5);

    // R2/R3/R4/R5 sweep of load values
    wreg(8'h28, 1);
    for (int n = 1; n <= 20; n++) begin
      wreg(8'h20, n);
      rreg(8'h24, v); check("R2 cur after load", v, n);
      repeat (3) @(negedge clk);
      rreg(8'h24, v); check("R3 no tick hold", v, n);
      for (int k = 1; k < n; k++) pulse_tick();
      rreg(8'h24, v); check("R3 count down", v, 1);
      rreg(8'h30, v); check("R4 not yet pending", v, 0);
      pulse_tick();
      rreg(8'h30, v); check("R4 pending at zero", v, 1);
      pulse_tick();
      rreg(8'h24, v); check("R4 hold zero", v, 0);
      wreg(8'h30, 0);
      rreg(8'h30, v); check("R5 write zero keeps", v, 1);
      wreg(8'h30, 1);
      rreg(8'h30, v); check("R5 w1c clears", v, 0);
      pulse_tick();
      rreg(8'h30, v); check("R4 once only", v, 0);
    end

    // R4 load zero never sets pending
    wreg(8'h20, 0);
    repeat (2) pulse_tick();
    rreg(8'h30, v); check("R4 zero load no flag", v, 0);

    // R11 load wins over tick
    wreg(8'h20, 9);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'h20; wdata = 3;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rreg(8'h24, v); check("R11 load priority", v, 3);

    // R6 set wins over clear; R7/R8 outputs
    wreg(8'h20, 1);
    @(negedge clk); tick = 1'b1; wr = 1'b1; addr = 8'h30; wdata = 1;
    @(negedge clk); tick = 1'b0; wr = 1'b0;
    rreg(8'h30, v); check("R6 set wins", v, 1);
    check("R7 irq masked", {31'b0, irq}, 0);
    check("R8 wake masked", {31'b0, wake}, 0);
    wreg(8'h2C, 1);
    @(negedge clk);
    check("R7 irq on", {31'b0, irq}, 1);
    check("R8 wake off with irq on", {31'b0, wake}, 0);
    wreg(8'h50, 1);
    @(negedge clk);
    check("R8 wake on", {31'b0, wake}, 1);
    wreg(8'h30, 1);
    @(negedge clk);
    check("R7 irq off after clear", {31'b0, irq}, 0);
    check("R8 wake off after clear", {31'b0, wake}, 0);

    // R9 second source
    @(negedge clk); match = 1'b1;
    @(negedge clk); match = 1'b0;
    rreg(8'h4C, v); check("R9 match ignored", v, 0);
    wreg(8'h44, 1);
    wreg(8'h48, 1);
    @(negedge clk); match = 1'b1;
    @(negedge clk); match = 1'b0;
    rreg(8'h4C, v); check("R9 match sets", v, 1);
    check("R7 irq second source", {31'b0, irq}, 1);
    check("R8 wake ignores second", {31'b0, wake}, 0);
    wreg(8'h4C, 1);
    rreg(8'h4C, v); check("R9 clear", v, 0);
    @(negedge clk);
    check("R7 irq drops", {31'b0, irq}, 0);

    // R10 unmapped and latency
    rreg(8'h44, v); check("R10 mapped read", v, 1);
    rreg(8'h04, v); check("R10 unmapped zero", v, 0);
    @(negedge clk); check("R10 rdata held", rdata, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule